// File: doc/BRIEF.md
# Program Memory Indirect Access Sequencer

This block is a multi-cycle sequencer that lends the program counter to three indirect operations against a byte-wide program memory. A table load fetches one byte into the accumulator. An indirect jump fetches a new low program-counter byte from a table. A vector fetch loads a full two-byte vector into the program counter. For the first two operations, the memory pointer is built by placing the accumulator in the low byte of the program counter, beside the current upper byte.

The surrounding core pulses `start_i` with an operation code, the current accumulator, the current program counter and, for vector fetches, a vector address. The sequencer issues one or two reads on a synchronous read port. The memory returns each read one cycle after the request. The sequencer then pulses `done_o` for one cycle. The results on `acc_o` and `pc_o` are valid from that cycle on and hold until the next accepted start. Between start and done, these outputs carry working values: during a table load the accumulator and the low byte are swapped.

Top module: `pm_indirect_seq`

## Requirements
- R1: After reset, `acc_o` and `pc_o` are 0 and `done_o` and `mem_re_o` are 0.
- R2: Op code 0 (table load) issues a single read at address {`pc_i`[14:8], `acc_i`}. When done, `acc_o` holds the byte returned.
- R3: When a table load completes, `pc_o` is bit-identical to the `pc_i` given at start.
- R4: Op code 1 (indirect jump) issues a single read at {`pc_i`[14:8], `acc_i`}. When done, `pc_o`[7:0] is the byte returned, `pc_o`[14:8] equals `pc_i`[14:8], and `acc_o` equals `acc_i`.
- R5: Op code 2 (vector) reads `vec_addr_i` with bit 0 cleared and then the next address. The first byte is the high byte; its bit 7 is dropped and bits 6:0 become `pc_o`[14:8]. The second byte becomes `pc_o`[7:0]. `acc_o` equals `acc_i`.
- R6: `mem_re_o` is high for exactly one cycle per read, and the data is taken in the following cycle. `done_o` is a one-cycle pulse. If start is sampled at edge k, `done_o` is high in the cycle after edge k+2 for op codes 0 and 1, and in the cycle after edge k+4 for op code 2.
- R7: A start strobe that arrives while an operation is in progress is ignored. It does not change that operation's reads, result or done timing, and no extra done follows.
- R8: A start strobe with op code 3 is ignored: no read, no done, and `acc_o`/`pc_o` keep their values.
- R9: A start strobe raised in the cycle in which `done_o` is high is accepted, so operations can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, sampled when idle |
| op_i | input | 2 | 0 table load, 1 indirect jump, 2 vector, 3 reserved |
| acc_i | input | 8 | Accumulator value at start |
| pc_i | input | 15 | Program counter value at start |
| vec_addr_i | input | 15 | Vector location for op code 2 |
| mem_re_o | output | 1 | Program memory read request |
| mem_addr_o | output | 15 | Program memory read address |
| mem_data_i | input | 8 | Read data, valid one cycle after the request |
| acc_o | output | 8 | Resulting accumulator |
| pc_o | output | 15 | Resulting program counter |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The assertions check several properties on every cycle. Done is a single-cycle pulse. Every read request is followed by a cycle without one. The second vector read follows the first by two cycles, at the next address. At done, a table load has left the program counter exactly as captured at start, and an indirect jump has left the upper byte and the accumulator untouched. Only the bench scenarios can show the rest. These are the data values fetched, the exact latency to done, that a start during a busy or reserved operation has no effect at the ports, and that a start is accepted in the done cycle.

// File: rtl/pm_seq_pkg.sv
package pm_seq_pkg;
  typedef enum logic [1:0] {
    OP_TBL_LD  = 2'd0,
    OP_JMP_IND = 2'd1,
    OP_VEC     = 2'd2,
    OP_RSVD    = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_REQ0 = 3'd1,
    ST_CAP0 = 3'd2,
    ST_REQ1 = 3'd3,
    ST_CAP1 = 3'd4
  } st_e;
endpackage

// File: rtl/pmis_fsm.sv
module pmis_fsm
  import pm_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [1:0] op_i,
  output logic       accept_o,
  output st_e        st_o,
  output op_e        op_o,
  output logic       done_o
);
  st_e  st_q, st_d;
  op_e  op_q;
  logic done_q;

  assign accept_o = start_i && (st_q == ST_IDLE) && (op_e'(op_i) != OP_RSVD);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (accept_o) st_d = ST_REQ0;
      ST_REQ0: st_d = ST_CAP0;
      ST_CAP0: st_d = (op_q == OP_VEC) ? ST_REQ1 : ST_IDLE;
      ST_REQ1: st_d = ST_CAP1;
      ST_CAP1: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      op_q   <= OP_TBL_LD;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      if (accept_o) op_q <= op_e'(op_i);
      done_q <= ((st_q == ST_CAP0) && (op_q != OP_VEC)) || (st_q == ST_CAP1);
    end
  end

  assign st_o   = st_q;
  assign op_o   = op_q;
  assign done_o = done_q;
endmodule

// File: rtl/pmis_datapath.sv
module pmis_datapath
  import pm_seq_pkg::*;
#(
  parameter int ACC_W = 8,
  parameter int PC_W  = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             accept_i,
  input  logic [1:0]       op_i,
  input  st_e              st_i,
  input  op_e              op_q_i,
  input  logic [ACC_W-1:0] acc_i,
  input  logic [PC_W-1:0]  pc_i,
  input  logic [PC_W-1:0]  vec_addr_i,
  input  logic [ACC_W-1:0] mem_data_i,
  output logic             mem_re_o,
  output logic [PC_W-1:0]  mem_addr_o,
  output logic [ACC_W-1:0] acc_o,
  output logic [PC_W-1:0]  pc_o
);
  localparam int PCH_W = PC_W - ACC_W;

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] pcl_q;
  logic [PCH_W-1:0] pch_q;
  logic [PC_W-1:0]  vec_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      pcl_q <= '0;
      pch_q <= '0;
      vec_q <= '0;
    end else if (accept_i) begin
      pch_q <= pc_i[PC_W-1:ACC_W];
      unique case (op_e'(op_i))
        OP_TBL_LD: begin
          // exchange: pointer low byte takes the accumulator, saved PCL parks in acc
          acc_q <= pc_i[ACC_W-1:0];
          pcl_q <= acc_i;
        end
        OP_JMP_IND: begin
          acc_q <= acc_i;
          pcl_q <= acc_i;
        end
        default: begin
          acc_q <= acc_i;
          pcl_q <= pc_i[ACC_W-1:0];
          vec_q <= {vec_addr_i[PC_W-1:1], 1'b0};
        end
      endcase
    end else if (st_i == ST_CAP0) begin
      unique case (op_q_i)
        OP_TBL_LD: begin
          acc_q <= mem_data_i;
          pcl_q <= acc_q;
        end
        OP_JMP_IND: pcl_q <= mem_data_i;
        default:    pch_q <= mem_data_i[PCH_W-1:0];
      endcase
    end else if (st_i == ST_CAP1) begin
      pcl_q <= mem_data_i;
    end
  end

  always_comb begin
    mem_re_o   = (st_i == ST_REQ0) || (st_i == ST_REQ1);
    mem_addr_o = {pch_q, pcl_q};
    if (op_q_i == OP_VEC) mem_addr_o = {vec_q[PC_W-1:1], st_i == ST_REQ1};
  end

  assign acc_o = acc_q;
  assign pc_o  = {pch_q, pcl_q};
endmodule

// File: rtl/pm_indirect_seq.sv
module pm_indirect_seq
  import pm_seq_pkg::*;
#(
  parameter int ACC_W = 8,
  parameter int PC_W  = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [1:0]       op_i,
  input  logic [ACC_W-1:0] acc_i,
  input  logic [PC_W-1:0]  pc_i,
  input  logic [PC_W-1:0]  vec_addr_i,
  output logic             mem_re_o,
  output logic [PC_W-1:0]  mem_addr_o,
  input  logic [ACC_W-1:0] mem_data_i,
  output logic [ACC_W-1:0] acc_o,
  output logic [PC_W-1:0]  pc_o,
  output logic             done_o
);
  logic accept;
  st_e  st;
  op_e  op_q;

  pmis_fsm u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .op_i    (op_i),
    .accept_o(accept),
    .st_o    (st),
    .op_o    (op_q),
    .done_o  (done_o)
  );

  pmis_datapath #(.ACC_W(ACC_W), .PC_W(PC_W)) u_dp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .accept_i  (accept),
    .op_i      (op_i),
    .st_i      (st),
    .op_q_i    (op_q),
    .acc_i     (acc_i),
    .pc_i      (pc_i),
    .vec_addr_i(vec_addr_i),
    .mem_data_i(mem_data_i),
    .mem_re_o  (mem_re_o),
    .mem_addr_o(mem_addr_o),
    .acc_o     (acc_o),
    .pc_o      (pc_o)
  );
endmodule

// File: rtl/pmis_checker.sv
module pmis_checker
  import pm_seq_pkg::*;
#(
  parameter int ACC_W = 8,
  parameter int PC_W  = 15
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             accept,
  input op_e              op_q,
  input logic [ACC_W-1:0] acc_i,
  input logic [PC_W-1:0]  pc_i,
  input logic             mem_re_o,
  input logic [PC_W-1:0]  mem_addr_o,
  input logic [ACC_W-1:0] acc_o,
  input logic [PC_W-1:0]  pc_o,
  input logic             done_o
);
  logic [PC_W-1:0]  pc_sv;
  logic [ACC_W-1:0] acc_sv;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_sv  <= '0;
      acc_sv <= '0;
    end else if (accept) begin
      pc_sv  <= pc_i;
      acc_sv <= acc_i;
    end
  end

  a_r6_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r6_read_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_re_o |=> !mem_re_o);

  a_r3_pc_restored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && op_q == OP_TBL_LD) |-> pc_o == pc_sv);

  a_r4_jump_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && op_q == OP_JMP_IND) |->
      (pc_o[PC_W-1:ACC_W] == pc_sv[PC_W-1:ACC_W] && acc_o == acc_sv));

  a_r5_vec_pair: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_re_o && op_q == OP_VEC && mem_addr_o[0]) |->
      ($past(mem_re_o, 2) && $past(mem_addr_o, 2) == {mem_addr_o[PC_W-1:1], 1'b0}));
endmodule

bind pm_indirect_seq pmis_checker #(.ACC_W(ACC_W), .PC_W(PC_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .accept    (accept),
  .op_q      (op_q),
  .acc_i     (acc_i),
  .pc_i      (pc_i),
  .mem_re_o  (mem_re_o),
  .mem_addr_o(mem_addr_o),
  .acc_o     (acc_o),
  .pc_o      (pc_o),
  .done_o    (done_o)
);

// File: tb/pm_indirect_seq_tb_top.sv
module pm_indirect_seq_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  op = 2'd0;
  logic [7:0]  acc = '0;
  logic [14:0] pc = '0;
  logic [14:0] vaddr = '0;
  logic        re;
  logic [14:0] addr;
  logic [7:0]  rdata = '0;
  logic [7:0]  acc_q;
  logic [14:0] pc_q;
  logic        done;

  int checks = 0;
  int errors = 0;
  int n_reads = 0;
  logic [14:0] rd_addr [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  pm_indirect_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op), .acc_i(acc),
    .pc_i(pc), .vec_addr_i(vaddr), .mem_re_o(re), .mem_addr_o(addr),
    .mem_data_i(rdata), .acc_o(acc_q), .pc_o(pc_q), .done_o(done)
  );

  function automatic logic [7:0] mem_f(input logic [14:0] a);
    return a[7:0] ^ {a[14:8], 1'b1} ^ 8'h5A;
  endfunction

  always @(posedge clk) begin
    if (re) begin
      rdata <= mem_f(addr);
      if (n_reads < 2) rd_addr[n_reads] <= addr;
      n_reads <= n_reads + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // pulse start at a negedge, return cycles until done is seen
  task automatic launch(input logic [1:0] o, input logic [7:0] a, input logic [14:0] p,
                        input logic [14:0] v, output int lat);
    n_reads = 0;
    op = o; acc = a; pc = p; vaddr = v; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 12) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic t_reset();
    chk("R1 acc", acc_q, 0);
    chk("R1 pc", pc_q, 0);
    chk("R1 done", done, 0);
    chk("R1 re", re, 0);
  endtask

  task automatic t_tbl(input logic [7:0] a, input logic [14:0] p);
    int lat;
    launch(2'd0, a, p, 15'h0, lat);
    chk("R6 tbl latency", lat, 3);
    chk("R2 reads", n_reads, 1);
    chk("R2 addr", rd_addr[0], {p[14:8], a});
    chk("R2 acc", acc_q, mem_f({p[14:8], a}));
    chk("R3 pc", pc_q, p);
    @(negedge clk);
    chk("R6 done low", done, 0);
  endtask

  task automatic t_jmp(input logic [7:0] a, input logic [14:0] p);
    int lat;
    launch(2'd1, a, p, 15'h0, lat);
    chk("R6 jmp latency", lat, 3);
    chk("R4 addr", rd_addr[0], {p[14:8], a});
    chk("R4 pc", pc_q, {p[14:8], mem_f({p[14:8], a})});
    chk("R4 acc", acc_q, a);
    @(negedge clk);
  endtask

  task automatic t_vec(input logic [7:0] a, input logic [14:0] p, input logic [14:0] v);
    int lat;
    logic [14:0] b;
    b = {v[14:1], 1'b0};
    launch(2'd2, a, p, v, lat);
    chk("R6 vec latency", lat, 5);
    chk("R5 reads", n_reads, 2);
    chk("R5 addr0", rd_addr[0], b);
    chk("R5 addr1", rd_addr[1], b + 15'd1);
    chk("R5 pc", pc_q, {mem_f(b)[6:0], mem_f(b + 15'd1)});
    chk("R5 acc", acc_q, a);
    @(negedge clk);
  endtask

  task automatic t_busy();
    int lat;
    n_reads = 0;
    op = 2'd0; acc = 8'h3C; pc = 15'h1A55; start = 1'b1;
    @(negedge clk);
    op = 2'd1; acc = 8'hEE; pc = 15'h7F00;   // arrives while busy
    @(negedge clk);
    start = 1'b0;
    lat = 2;
    while (!done && lat < 12) begin
      @(negedge clk);
      lat++;
    end
    chk("R7 latency", lat, 3);
    chk("R7 acc", acc_q, mem_f(15'h1A3C));
    chk("R7 pc", pc_q, 15'h1A55);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk("R7 no extra done", done, 0);
    end
    chk("R7 reads", n_reads, 1);
  endtask

  task automatic t_rsvd();
    logic [7:0]  a0;
    logic [14:0] p0;
    a0 = acc_q; p0 = pc_q;
    n_reads = 0;
    op = 2'd3; acc = 8'h11; pc = 15'h2222; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 6; i++) begin
      chk("R8 no done", done, 0);
      @(negedge clk);
    end
    chk("R8 reads", n_reads, 0);
    chk("R8 acc", acc_q, a0);
    chk("R8 pc", pc_q, p0);
  endtask

  task automatic t_b2b();
    int lat;
    launch(2'd0, 8'h80, 15'h0312, 15'h0, lat);
    chk("R9 first done", done, 1);
    // start the next op in the done cycle
    launch(2'd1, 8'h07, 15'h4499, 15'h0, lat);
    chk("R9 second latency", lat, 3);
    chk("R9 pc", pc_q, {7'h44, mem_f(15'h4407)});
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_tbl(8'h05, 15'h0402);
    t_tbl(8'hFF, 15'h7FFF);
    t_tbl(8'h00, 15'h0000);
    t_jmp(8'h26, 15'h0132);
    t_jmp(8'hC4, 15'h36AB);
    t_vec(8'h99, 15'h1234, 15'h7FF1);
    t_vec(8'h00, 15'h0000, 15'h0100);
    t_busy();
    t_rsvd();
    t_b2b();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule